// File: doc/BRIEF.md
# Mode-Switched Eight-Pin GPIO Port with Address Takeover

This block is an eight-pin general-purpose port that sits on a small register bus. Software picks each pin's direction, writes the value that output pins drive, reads back the levels seen on the pins, and turns on a pull-up or open-drain drive per pin. An operating-mode input decides who owns the pins. In the two expanded modes, the low pins always carry external address bits. The upper pins carry address bits only where software has set their direction bit.

The direction register cannot be read back. It survives a manual reset but is cleared by a power-on reset or by hardware standby. When the chip enters software standby, a control input decides what the address pins do. They either freeze at the last address they drove or release the line so that it floats. Pad cells, the memory controller that supplies the address, and clocking all lie outside the block and appear as plain signals.

Top module: `mode_gpio_port`

## Requirements
- R1: A write takes effect at the clock edge on which `bus_wr` is high. The register offsets are: 0 direction, 1 output data, 2 pin level, 3 pull-up enable, 4 open-drain enable. Reads of offsets 1, 3 and 4 return the stored value combinationally.
- R2: When `por_n` is low, or `hw_stby` is high at a clock edge, the direction, data, pull-up and open-drain registers are cleared to zero.
- R3: When `man_rst` is high at a clock edge, the data, pull-up and open-drain registers are cleared, the direction register keeps its contents, and any write in that cycle is dropped.
- R4: For any `mode` other than 4 and 5, a direction bit of 1 makes the pin drive its data bit with `pin_oe` high. A direction bit of 0 makes it an input, with `pin_oe` and `pin_out` low.
- R5: In modes 4 and 5, pins 4 to 0 drive the matching bits of `addr_bus_in` with `pin_oe` high, whatever their direction bits hold.
- R6: In modes 4 and 5, each of pins 7 to 5 drives its address bit when its direction bit is 1, and is an input when its direction bit is 0.
- R7: While `sw_stby` is high, pins that carry address bits act on `ope`. With `ope` high they hold the address captured at the last edge before standby. With `ope` low their `pin_oe` is low. GPIO-owned pins are not affected.
- R8: `pin_pu` of a pin is high only when its pull-up bit is 1 and the pin is currently an input.
- R9: For a GPIO output pin whose open-drain bit is 1, a data bit of 0 drives 0 with `pin_oe` high, and a data bit of 1 sets `pin_oe` low.
- R10: A read of offset 2 returns `pin_in` as it stood two clock edges earlier. Writes to offset 2 are ignored.
- R11: A read of offset 0 returns all ones.
- R12: Offsets 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby, synchronous clear |
| sw_stby | input | 1 | Software standby state |
| ope | input | 1 | Address pins hold (1) or float (0) during software standby |
| mode | input | 3 | Operating mode; 4 and 5 are expanded |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| addr_bus_in | input | 8 | Address bits from the memory controller |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Pull-up enable per pin |

## Verification
On every cycle, the assertions check the following. The low pins are address-driven in the expanded modes. Floating address pins have their enable low. A pull-up never coincides with a driving pin. A hardware standby leaves the registers cleared. A manual reset leaves the direction unchanged. Unmapped offsets read zero. Frozen address pins stay put while standby and hold are both active. Only the bench's behavioural model, compared on every clock, can show the rest. That covers the two-edge lag of the pin-level read, the open-drain encoding, the write-only direction register that survives manual reset while the data is lost, and the sequence of mode and standby changes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int OFS_W = 3;

   typedef enum logic [OFS_W-1:0] {
      OFS_DIR  = 3'd0,
      OFS_DATA = 3'd1,
      OFS_PINS = 3'd2,
      OFS_PULL = 3'd3,
      OFS_ODRN = 3'd4
   } reg_ofs_e;

   function automatic logic mode_is_expanded(input logic [2:0] m);
      return (m == 3'd4) || (m == 3'd5);
   endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int W = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             man_rst,
   input  logic             hw_stby,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] addr,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     dir_q,
   output logic [W-1:0]     data_q,
   output logic [W-1:0]     pull_q,
   output logic [W-1:0]     odrn_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         dir_q  <= '0;
         data_q <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else if (hw_stby) begin
         dir_q  <= '0;
         data_q <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else if (man_rst) begin
         data_q <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else if (wr_en) begin
         case (addr)
            OFS_DIR:  dir_q  <= wdata;
            OFS_DATA: data_q <= wdata;
            OFS_PULL: pull_q <= wdata;
            OFS_ODRN: odrn_q <= wdata;
            default: ;
         endcase
      end
   end

   // R2: hardware standby leaves every control register cleared
   p_hw_clear_r2: assert property (@(posedge clk) disable iff (!por_n)
      hw_stby |=> (dir_q == '0) && (data_q == '0) && (pull_q == '0) && (odrn_q == '0));

   // R3: manual reset never disturbs the direction register
   p_dir_kept_r3: assert property (@(posedge clk) disable iff (!por_n)
      (man_rst && !hw_stby) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int W     = 8,
   parameter int FIXED = 5
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         expanded,
   input  logic         sw_stby,
   input  logic         ope,
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] data_q,
   input  logic [W-1:0] pull_q,
   input  logic [W-1:0] odrn_q,
   input  logic [W-1:0] addr_live,
   input  logic [W-1:0] addr_hold,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] pin_pu
);
   logic [W-1:0] addr_own;

   generate
      if (FIXED < 1 || FIXED > W) begin : g_bad_fixed
         $error("gpio_pin_mux: FIXED must lie in 1..W");
      end
      for (genvar i = 0; i < W; i++) begin : g_pin
         localparam bit ALWAYS_ADDR = (i < FIXED);
         logic gpio_drv;

         assign addr_own[i] = expanded && (ALWAYS_ADDR || dir_q[i]);
         assign gpio_drv    = !expanded && dir_q[i];

         always_comb begin
            pin_out[i] = 1'b0;
            pin_oe[i]  = 1'b0;
            if (addr_own[i]) begin
               if (!(sw_stby && !ope)) begin
                  pin_out[i] = sw_stby ? addr_hold[i] : addr_live[i];
                  pin_oe[i]  = 1'b1;
               end
            end else if (gpio_drv) begin
               if (odrn_q[i]) begin
                  pin_out[i] = 1'b0;
                  pin_oe[i]  = !data_q[i];
               end else begin
                  pin_out[i] = data_q[i];
                  pin_oe[i]  = 1'b1;
               end
            end
         end

         assign pin_pu[i] = pull_q[i] && !addr_own[i] && !gpio_drv;
      end
   endgenerate

   // R5: low pins carry the live address in expanded modes outside standby
   p_fixed_addr_r5: assert property (@(posedge clk) disable iff (!por_n)
      (expanded && !sw_stby) |->
         (pin_oe[FIXED-1:0] == {FIXED{1'b1}}) && (pin_out[FIXED-1:0] == addr_live[FIXED-1:0]));

   // R7: floating standby releases every address-owned pin
   p_float_r7: assert property (@(posedge clk) disable iff (!por_n)
      (sw_stby && !ope) |-> ((pin_oe & addr_own) == '0));

   // R8: a pull-up is never enabled on a driving pin
   p_pu_input_r8: assert property (@(posedge clk) disable iff (!por_n)
      (pin_pu & pin_oe) == '0);
endmodule

// File: rtl/mode_gpio_port.sv
module mode_gpio_port
   import gpio_port_pkg::*;
#(
   parameter int W           = 8,
   parameter int FIXED       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             man_rst,
   input  logic             hw_stby,
   input  logic             sw_stby,
   input  logic             ope,
   input  logic [2:0]       mode,
   input  logic [OFS_W-1:0] bus_addr,
   input  logic             bus_wr,
   input  logic [W-1:0]     bus_wdata,
   output logic [W-1:0]     bus_rdata,
   input  logic [W-1:0]     addr_bus_in,
   input  logic [W-1:0]     pin_in,
   output logic [W-1:0]     pin_out,
   output logic [W-1:0]     pin_oe,
   output logic [W-1:0]     pin_pu
);
   logic [W-1:0] dir_q, data_q, pull_q, odrn_q, pins_q, addr_hold;
   logic         expanded;
   logic         past_ok;

   assign expanded = mode_is_expanded(mode);

   gpio_regs #(.W(W)) u_regs (
      .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby),
      .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .odrn_q(odrn_q)
   );

   gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .d(pin_in), .q(pins_q)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         addr_hold <= '0;
         past_ok   <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (!sw_stby) addr_hold <= addr_bus_in;
      end
   end

   gpio_pin_mux #(.W(W), .FIXED(FIXED)) u_mux (
      .clk(clk), .por_n(por_n), .expanded(expanded), .sw_stby(sw_stby), .ope(ope),
      .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .odrn_q(odrn_q),
      .addr_live(addr_bus_in), .addr_hold(addr_hold),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
   );

   always_comb begin
      case (bus_addr)
         OFS_DIR:  bus_rdata = '1;
         OFS_DATA: bus_rdata = data_q;
         OFS_PINS: bus_rdata = pins_q;
         OFS_PULL: bus_rdata = pull_q;
         OFS_ODRN: bus_rdata = odrn_q;
         default:  bus_rdata = '0;
      endcase
   end

   // R12: offsets beyond the map read as zero
   p_unmapped_r12: assert property (@(posedge clk) disable iff (!por_n)
      (bus_addr > 3'd4) |-> (bus_rdata == '0));

   // R7: frozen address pins keep their value across a held standby
   p_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
      (past_ok && sw_stby && $past(sw_stby) && ope && $past(ope) && expanded
       && $past(expanded) && !$past(hw_stby))
      |-> $stable(pin_out[FIXED-1:0]));
endmodule

// File: tb/mode_gpio_port_tb_top.sv
module mode_gpio_port_tb_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, man_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0, ope = 1'b0;
   logic [2:0] mode = 3'd1, bus_addr = 3'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0, addr_bus_in = '0, pin_in = '0;
   logic [7:0] bus_rdata, pin_out, pin_oe, pin_pu;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mode_gpio_port dut_i (
      .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .ope(ope), .mode(mode), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .addr_bus_in(addr_bus_in), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
   );

   // behavioural reference state
   logic [7:0] m_dir, m_data, m_pull, m_odrn, m_hold;
   logic [7:0] hist[$];

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_dir = 0; m_data = 0; m_pull = 0; m_odrn = 0; m_hold = 0; hist = {};
      end else begin
         hist.push_front(pin_in);
         if (hist.size() > 2) void'(hist.pop_back());
         if (!sw_stby) m_hold = addr_bus_in;
         if (hw_stby) begin
            m_dir = 0; m_data = 0; m_pull = 0; m_odrn = 0;
         end else if (man_rst) begin
            m_data = 0; m_pull = 0; m_odrn = 0;
         end else if (bus_wr) begin
            if (bus_addr == 0) m_dir = bus_wdata;
            if (bus_addr == 1) m_data = bus_wdata;
            if (bus_addr == 3) m_pull = bus_wdata;
            if (bus_addr == 4) m_odrn = bus_wdata;
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (por_n && !done) begin
         logic [7:0] e_out, e_oe, e_pu, e_rd;
         bit ex;
         ex = (mode == 4) || (mode == 5);
         for (int i = 0; i < 8; i++) begin
            bit aown, gdrv;
            aown = ex && (i < 5 || m_dir[i]);
            gdrv = !ex && m_dir[i];
            e_out[i] = 0; e_oe[i] = 0;
            if (aown) begin
               if (!(sw_stby && !ope)) begin
                  e_oe[i] = 1;
                  e_out[i] = sw_stby ? m_hold[i] : addr_bus_in[i];
               end
            end else if (gdrv) begin
               if (m_odrn[i]) e_oe[i] = !m_data[i];
               else begin e_oe[i] = 1; e_out[i] = m_data[i]; end
            end
            e_pu[i] = m_pull[i] && !aown && !gdrv;
         end
         case (bus_addr)
            0: e_rd = 8'hFF;
            1: e_rd = m_data;
            2: e_rd = (hist.size() == 2) ? hist[1] : 8'h00;
            3: e_rd = m_pull;
            4: e_rd = m_odrn;
            default: e_rd = 8'h00;
         endcase
         chk(sw_stby && ex ? "R7 model pin_out" : ex ? "R5 model pin_out" : "R4 model pin_out", pin_out, e_out);
         chk(sw_stby && ex ? "R7 model pin_oe" : ex ? "R6 model pin_oe" : "R9 model pin_oe", pin_oe, e_oe);
         chk("R8 model pin_pu", pin_pu, e_pu);
         chk(bus_addr == 2 ? "R10 model rdata" : bus_addr == 0 ? "R11 model rdata" :
             bus_addr > 4 ? "R12 model rdata" : "R1 model rdata", bus_rdata, e_rd);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wr = 1; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
   endtask

   task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
      bus_addr = a;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      step(3);
      por_n = 1; step(1);
      rd("R2 data after power-on", 3'd1, 8'h00);
      rd("R2 pull after power-on", 3'd3, 8'h00);
      // R4 plain GPIO mode
      wr(3'd0, 8'hFF); wr(3'd1, 8'hA5);
      @(negedge clk);
      chk("R4 outputs drive data", pin_out, 8'hA5);
      chk("R4 all enables on", pin_oe, 8'hFF);
      wr(3'd0, 8'h0F);
      @(negedge clk);
      chk("R4 inputs released", pin_oe, 8'h0F);
      rd("R1 data readback", 3'd1, 8'hA5);
      rd("R11 direction reads ones", 3'd0, 8'hFF);
      // R8 pull-up on inputs only
      wr(3'd3, 8'hFF);
      @(negedge clk);
      chk("R8 pull-ups on inputs", pin_pu, 8'hF0);
      // R9 open drain on pins 0 and 1
      wr(3'd4, 8'h03);
      @(negedge clk);
      chk("R9 open-drain enables", pin_oe, 8'h0E);
      chk("R9 open-drain levels", pin_out, 8'h04);
      // R10 pin level read with two-edge lag
      pin_in = 8'h3C; step(1);
      rd("R10 one edge is too early", 3'd2, 8'h00);
      step(1);
      rd("R10 pin levels", 3'd2, 8'h3C);
      wr(3'd2, 8'hFF);
      rd("R10 write ignored", 3'd2, 8'h3C);
      // R12 unmapped offsets
      wr(3'd6, 8'hFF);
      rd("R12 unmapped reads zero", 3'd6, 8'h00);
      rd("R12 data untouched", 3'd1, 8'hA5);
      rd("R12 open-drain untouched", 3'd4, 8'h03);
      // R5 and R6 expanded mode
      wr(3'd4, 8'h00); wr(3'd0, 8'h20);
      mode = 3'd4; addr_bus_in = 8'h9B;
      @(negedge clk);
      chk("R5 R6 address enables", pin_oe, 8'h3F);
      chk("R5 R6 address values", pin_out, 8'h1B);
      mode = 3'd5; wr(3'd0, 8'hE0);
      @(negedge clk);
      chk("R6 upper pins join address", pin_oe, 8'hFF);
      wr(3'd0, 8'h20);
      // R7 standby hold then float
      step(1);
      ope = 1; sw_stby = 1; step(1);
      addr_bus_in = 8'h44; step(2);
      @(negedge clk);
      chk("R7 held address", pin_out, 8'h1B);
      chk("R7 held enables", pin_oe, 8'h3F);
      ope = 0;
      @(negedge clk);
      chk("R7 address pins float", pin_oe, 8'h00);
      sw_stby = 0; step(1);
      // R3 manual reset keeps direction
      mode = 3'd1; wr(3'd0, 8'h0F); wr(3'd1, 8'hFF);
      man_rst = 1; step(1); man_rst = 0;
      @(negedge clk);
      chk("R3 direction kept", pin_oe, 8'h0F);
      chk("R3 data cleared", pin_out, 8'h00);
      rd("R3 pull cleared", 3'd3, 8'h00);
      // R2 hardware standby clears direction
      hw_stby = 1; step(1); hw_stby = 0;
      @(negedge clk);
      chk("R2 direction cleared", pin_oe, 8'h00);
      step(2);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule